// File: doc/BRIEF.md
# Interleaved Multiport ECC Memory Distributor

This block connects three requesting ports (processor, I/O and external) to a set of independently cycling memory banks. Each port issues single-word reads and writes through a valid/ready handshake. Each clock, one request at most is granted by fixed priority. The low-order address bits select the bank. A bank that has started an access stays unavailable for a configurable number of cycles. Requests to other banks can still be accepted on every clock, so a run of consecutive addresses streams at one word per cycle.

Writes store a 72-bit codeword: the 64-bit data word plus eight check bits of an extended Hamming code. Reads go through a single-error-correct, double-error-detect decoder. The corrected word is returned to the requesting port two cycles after its grant. Any error found is reported on a separate error channel with the port and the address. A counter tallies corrected events. A fault-injection mask on the write path lets stored codewords be corrupted on purpose.

Top module: `mem_distributor`

## Requirements
- R1: Reset clears every bank timer, `rdValid`, `errValid` and `corrCount`, so that right after reset any single request is accepted at once. Reset does not alter the stored words.
- R2: The bank index is the low `$clog2(NUM_BANKS)` address bits and the row is the remaining upper bits. Accesses to consecutive addresses are each accepted without waiting.
- R3: A bank granted in cycle c refuses all requests in cycles c+1 through c+BANK_BUSY_CYCLES-1 and can be granted again in cycle c+BANK_BUSY_CYCLES.
- R4: Fixed priority applies: port 0 (processor) over port 1 (I/O) over port 2 (external). At most one `reqReady` bit is high per cycle, and only for a port whose `reqValid` is high.
- R5: A higher-priority request aimed at a busy bank does not block a lower-priority request to a free bank in the same cycle.
- R6: A write stores its word. A read granted in cycle c raises `rdValid[port]` for exactly cycle c+2, with the stored word on `rdData`. Writes produce no `rdValid`.
- R7: Stored codeword layout: bit 0 is overall parity, bits 1, 2, 4, 8, 16, 32 and 64 are Hamming check bits, and data bits 0..63 fill the remaining positions in ascending order. On a granted write, `injFlip` is XORed into the codeword before it is stored.
- R8: A single flipped bit in any of the 72 codeword positions is corrected in `rdData`. In that case `errValid`=1 and `errUncorr`=0 in the `rdValid` cycle.
- R9: Two flipped bits give `errValid`=1 and `errUncorr`=1 in the `rdValid` cycle.
- R10: When `errValid` is high, `errPort` holds the requesting port id (0 processor, 1 I/O, 2 external) and `errAddr` holds the request's address.
- R11: `corrCount` rises by one for each corrected read and the new value is visible in the `errValid` cycle. Clean and uncorrectable reads leave it unchanged.
- R12: A read of an undisturbed codeword gives `errValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 3 | Request valid per port |
| reqReady | output | 3 | Grant per port, combinational |
| reqWrite | input | 3 | Write enable per port |
| reqAddr | input | 3 x ADDR_W | Word address per port |
| reqWdata | input | 3 x 64 | Write data per port |
| injFlip | input | 72 | Codeword bits inverted on a granted write |
| rdValid | output | 3 | Read-return pulse per port |
| rdData | output | 64 | Corrected read data |
| errValid | output | 1 | Error report strobe |
| errUncorr | output | 1 | Report is uncorrectable |
| errPort | output | 2 | Port id of the failing read |
| errAddr | output | ADDR_W | Address of the failing read |
| corrCount | output | CNT_W | Count of corrected reads |

## Verification
Two things can meet in one cycle: a read return carrying an error report, and the grant of a new request from another port. The bench sets this up by issuing reads from three ports on consecutive cycles to three different banks, the first read aimed at a word stored with a single injected flip. In the cycle the corrected word comes back, the bench checks the report's port, address and count, and at the same moment checks that the grant for the third port is high. It then checks that the two following returns arrive clean and in order.

// File: rtl/memdist_pkg.sv
package memdist_pkg;

  localparam int DATA_W    = 64;
  localparam int CODE_W    = 72;
  localparam int CHK_W     = 7;
  localparam int NUM_PORTS = 3;

  typedef enum logic [1:0] {
    PORT_CPU = 2'd0,
    PORT_IO  = 2'd1,
    PORT_EXT = 2'd2
  } portId_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    go;
    logic    wr;
    portId_e port;
  } accessStrobe_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              corr;
    logic              uncorr;
  } eccResult_t;

  function automatic logic [CODE_W-1:0] eccEncode(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] cw;
    int j;
    cw = '0;
    j  = 0;
    for (int i = 1; i < CODE_W; i++) begin
      if ((i & (i - 1)) != 0) begin
        cw[i] = d[j];
        j++;
      end
    end
    for (int k = 0; k < CHK_W; k++) begin
      logic p;
      p = 1'b0;
      for (int i = 1; i < CODE_W; i++)
        if (i[k]) p = p ^ cw[i];
      cw[1 << k] = p;
    end
    cw[0] = ^cw[CODE_W-1:1];
    return cw;
  endfunction

  function automatic eccResult_t eccDecode(input logic [CODE_W-1:0] cwIn);
    logic [CODE_W-1:0] cw;
    logic [CHK_W-1:0]  syn;
    logic              par;
    eccResult_t        r;
    int j;
    cw  = cwIn;
    syn = '0;
    for (int k = 0; k < CHK_W; k++)
      for (int i = 1; i < CODE_W; i++)
        if (i[k]) syn[k] = syn[k] ^ cw[i];
    par      = ^cw;
    r.corr   = 1'b0;
    r.uncorr = 1'b0;
    if (par) begin
      if (syn < 7'(CODE_W)) begin
        cw     = cw ^ (CODE_W'(1) << syn);
        r.corr = 1'b1;
      end else begin
        r.uncorr = 1'b1;
      end
    end else if (syn != '0) begin
      r.uncorr = 1'b1;
    end
    r.data = '0;
    j = 0;
    for (int i = 1; i < CODE_W; i++) begin
      if ((i & (i - 1)) != 0) begin
        r.data[j] = cw[i];
        j++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/memdist_ctrl.sv
module memdist_ctrl
  import memdist_pkg::*;
#(
  parameter int NUM_BANKS        = 8,
  parameter int BANK_BUSY_CYCLES = 4,
  localparam int BANK_W          = $clog2(NUM_BANKS)
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_PORTS-1:0]                reqValid,
  input  logic [NUM_PORTS-1:0]                reqWrite,
  input  logic [NUM_PORTS-1:0][BANK_W-1:0]    reqBank,
  output logic [NUM_PORTS-1:0]                reqReady,
  output accessStrobe_t                       stb
);

  localparam int TMR_W = (BANK_BUSY_CYCLES > 1) ? $clog2(BANK_BUSY_CYCLES) : 1;

  logic [NUM_BANKS-1:0] bankBusy;
  logic [1:0]           selPort;
  logic [BANK_W-1:0]    grantBank;

  // lowest index wins: scan from the bottom priority upward
  always_comb begin
    reqReady = '0;
    selPort  = '0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (reqValid[p] && !bankBusy[reqBank[p]]) begin
        reqReady    = '0;
        reqReady[p] = 1'b1;
        selPort     = 2'(p);
      end
    end
  end

  assign grantBank = reqBank[selPort];
  assign stb.go    = |reqReady;
  assign stb.wr    = reqWrite[selPort];
  assign stb.port  = portId_e'(selPort);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gTimer
    logic [TMR_W-1:0] tmr;
    always_ff @(posedge clk) begin
      if (rst)
        tmr <= '0;
      else if (stb.go && grantBank == BANK_W'(b))
        tmr <= TMR_W'(BANK_BUSY_CYCLES - 1);
      else if (tmr != '0)
        tmr <= tmr - 1'b1;
    end
    assign bankBusy[b] = (tmr != '0);
  end

  // R4
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reqReady));

  // R4
  grant_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (reqReady & ~reqValid) == '0);

  if (BANK_BUSY_CYCLES > 1) begin : gBusyChk
    // R3
    no_regrant_chk: assert property (@(posedge clk) disable iff (rst)
      stb.go |=> !(stb.go && grantBank == $past(grantBank)));
  end

endmodule

// File: rtl/memdist_dp.sv
module memdist_dp
  import memdist_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 10,
  parameter int CNT_W     = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = ADDR_W - BANK_W,
  localparam int DEPTH    = 1 << ROW_W
) (
  input  logic                              clk,
  input  logic                              rst,
  input  accessStrobe_t                     stb,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  reqAddr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  reqWdata,
  input  logic [CODE_W-1:0]                 injFlip,
  output logic [NUM_PORTS-1:0]              rdValid,
  output logic [DATA_W-1:0]                 rdData,
  output logic                              errValid,
  output logic                              errUncorr,
  output logic [1:0]                        errPort,
  output logic [ADDR_W-1:0]                 errAddr,
  output logic [CNT_W-1:0]                  corrCount
);

  logic [ADDR_W-1:0] selAddr;
  logic [BANK_W-1:0] selBank;
  logic [ROW_W-1:0]  selRow;
  logic [CODE_W-1:0] wrCode;

  assign selAddr = reqAddr[stb.port];
  assign selBank = selAddr[BANK_W-1:0];
  assign selRow  = selAddr[ADDR_W-1:BANK_W];
  assign wrCode  = eccEncode(reqWdata[stb.port]) ^ injFlip;

  logic [NUM_BANKS-1:0][CODE_W-1:0] bankRdVec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gStore
    logic [CODE_W-1:0] cells [DEPTH];
    logic [CODE_W-1:0] rdReg;
    always_ff @(posedge clk) begin
      if (stb.go && selBank == BANK_W'(b)) begin
        if (stb.wr) cells[selRow] <= wrCode;
        else        rdReg         <= cells[selRow];
      end
    end
    assign bankRdVec[b] = rdReg;
  end

  // stage 1: bank read in flight
  logic              s1Valid;
  portId_e           s1Port;
  logic [ADDR_W-1:0] s1Addr;
  logic [BANK_W-1:0] s1Bank;

  always_ff @(posedge clk) begin
    if (rst) s1Valid <= 1'b0;
    else     s1Valid <= stb.go && !stb.wr;
  end

  always_ff @(posedge clk) begin
    if (stb.go) begin
      s1Port <= stb.port;
      s1Addr <= selAddr;
      s1Bank <= selBank;
    end
  end

  eccResult_t dec;
  assign dec = eccDecode(bankRdVec[s1Bank]);

  // stage 2: corrected return and error report
  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid   <= '0;
      rdData    <= '0;
      errValid  <= 1'b0;
      errUncorr <= 1'b0;
      errPort   <= '0;
      errAddr   <= '0;
      corrCount <= '0;
    end else begin
      rdValid   <= s1Valid ? (NUM_PORTS'(1) << s1Port) : '0;
      errValid  <= s1Valid && (dec.corr || dec.uncorr);
      errUncorr <= s1Valid && dec.uncorr;
      if (s1Valid) begin
        rdData  <= dec.data;
        errPort <= s1Port;
        errAddr <= s1Addr;
      end
      if (s1Valid && dec.corr) corrCount <= corrCount + 1'b1;
    end
  end

  // R6
  rd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rdValid));

  // R6
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.go && !stb.wr) |-> ##2 (rdValid != '0));

  // R6
  write_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.go && stb.wr) |-> ##2 (rdValid == '0));

  // R9
  uncorr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    errUncorr |-> errValid);

  // R10
  report_with_return_chk: assert property (@(posedge clk) disable iff (rst)
    errValid |-> (rdValid != '0));

  // R11
  corr_count_chk: assert property (@(posedge clk) disable iff (rst)
    (errValid && !errUncorr) |-> corrCount == $past(corrCount) + CNT_W'(1));

endmodule

// File: rtl/mem_distributor.sv
module mem_distributor
  import memdist_pkg::*;
#(
  parameter int NUM_BANKS        = 8,
  parameter int ADDR_W           = 10,
  parameter int BANK_BUSY_CYCLES = 4,
  parameter int CNT_W            = 16,
  localparam int BANK_W          = $clog2(NUM_BANKS)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_PORTS-1:0]              reqValid,
  output logic [NUM_PORTS-1:0]              reqReady,
  input  logic [NUM_PORTS-1:0]              reqWrite,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  reqAddr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  reqWdata,
  input  logic [CODE_W-1:0]                 injFlip,
  output logic [NUM_PORTS-1:0]              rdValid,
  output logic [DATA_W-1:0]                 rdData,
  output logic                              errValid,
  output logic                              errUncorr,
  output logic [1:0]                        errPort,
  output logic [ADDR_W-1:0]                 errAddr,
  output logic [CNT_W-1:0]                  corrCount
);

  logic [NUM_PORTS-1:0][BANK_W-1:0] reqBank;
  accessStrobe_t                    stb;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gBankSel
    assign reqBank[p] = reqAddr[p][BANK_W-1:0];
  end

  memdist_ctrl #(
    .NUM_BANKS        (NUM_BANKS),
    .BANK_BUSY_CYCLES (BANK_BUSY_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqBank  (reqBank),
    .reqReady (reqReady),
    .stb      (stb)
  );

  memdist_dp #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .injFlip   (injFlip),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .errValid  (errValid),
    .errUncorr (errUncorr),
    .errPort   (errPort),
    .errAddr   (errAddr),
    .corrCount (corrCount)
  );

endmodule

// File: tb/sim_mem_distributor.sv
module sim_mem_distributor;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 6;
  localparam int NB   = 8;
  localparam int BUSY = 4;
  localparam int CW   = 16;
  localparam int NW   = 1 << AW;

  logic              clk = 1'b0;
  logic              rst;
  logic [2:0]        reqValid, reqReady, reqWrite;
  logic [2:0][AW-1:0] reqAddr;
  logic [2:0][63:0]  reqWdata;
  logic [71:0]       injFlip;
  logic [2:0]        rdValid;
  logic [63:0]       rdData;
  logic              errValid, errUncorr;
  logic [1:0]        errPort;
  logic [AW-1:0]     errAddr;
  logic [CW-1:0]     corrCount;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mem_distributor #(
    .NUM_BANKS (NB), .ADDR_W (AW), .BANK_BUSY_CYCLES (BUSY), .CNT_W (CW)
  ) u0 (
    .clk (clk), .rst (rst), .reqValid (reqValid), .reqReady (reqReady),
    .reqWrite (reqWrite), .reqAddr (reqAddr), .reqWdata (reqWdata),
    .injFlip (injFlip), .rdValid (rdValid), .rdData (rdData),
    .errValid (errValid), .errUncorr (errUncorr), .errPort (errPort),
    .errAddr (errAddr), .corrCount (corrCount)
  );

  int nChecks = 0;
  int nErrors = 0;
  int expCorr = 0;
  bit done    = 1'b0;
  logic [63:0] model [NW];

  function automatic logic [63:0] pat(input int a, input int salt);
    return (64'h9E37_79B9_7F4A_7C15 * 64'(a + salt + 1)) ^ 64'(a) ^ (64'(salt) << 40);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input int p, input int a, input bit wr,
                        input logic [63:0] d, input logic [71:0] flip,
                        output int waited);
    @(negedge clk);
    reqValid[p] = 1'b1;
    reqWrite[p] = wr;
    reqAddr[p]  = AW'(a);
    reqWdata[p] = d;
    injFlip     = flip;
    waited      = 0;
    #1;
    while (!reqReady[p]) begin
      @(negedge clk);
      #1;
      waited++;
    end
    @(posedge clk);
    @(negedge clk);
    reqValid[p] = 1'b0;
    injFlip     = '0;
  endtask

  task automatic readCheck(input int p, input int a, input logic [63:0] expD,
                           input bit chkData, input bit expErr, input bit expUnc,
                           input string dataReq);
    int w;
    access(p, a, 1'b0, '0, '0, w);
    @(posedge clk);
    @(negedge clk);
    check("R6", "rdValid", 80'(rdValid), 80'(3'b1 << p));
    if (chkData) check(dataReq, "rdData", 80'(rdData), 80'(expD));
    check(expErr ? (expUnc ? "R9" : "R8") : "R12", "errValid", 80'(errValid), 80'(expErr));
    check(expUnc ? "R9" : "R8", "errUncorr", 80'(errUncorr), 80'(expUnc));
    if (expErr) begin
      check("R10", "errPort", 80'(errPort), 80'(p));
      check("R10", "errAddr", 80'(errAddr), 80'(a));
    end
    check("R11", "corrCount", 80'(corrCount), 80'(expCorr));
  endtask

  initial begin
    int w;
    rst = 1'b1; reqValid = '0; reqWrite = '0; reqAddr = '0; reqWdata = '0; injFlip = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "rdValid", 80'(rdValid), 80'(0));
    check("R1", "errValid", 80'(errValid), 80'(0));
    check("R1", "corrCount", 80'(corrCount), 80'(0));
    for (int b = 0; b < NB; b++) begin
      @(negedge clk);
      reqValid[0] = 1'b1; reqWrite[0] = 1'b0; reqAddr[0] = AW'(b);
      #1 check("R1", "reqReady after reset", 80'(reqReady), 80'(3'b001));
      reqValid[0] = 1'b0;
    end

    // R2 sequential write sweep, every access accepted without waiting
    for (int a = 0; a < NW; a++) begin
      model[a] = pat(a, 0);
      access(a % 3, a, 1'b1, model[a], '0, w);
      check("R2", "write wait", 80'(w), 80'(0));
    end
    // R6 / R12 read sweep from rotating ports
    for (int a = 0; a < NW; a++)
      readCheck((a + 1) % 3, a, model[a], 1'b1, 1'b0, 1'b0, "R6");

    // R3 busy interval on bank 5
    @(negedge clk);
    reqValid[0] = 1'b1; reqWrite[0] = 1'b1; reqAddr[0] = AW'(5); reqWdata[0] = pat(5, 9);
    #1 check("R3", "first grant", 80'(reqReady), 80'(3'b001));
    model[5] = pat(5, 9);
    for (int k = 1; k <= BUSY; k++) begin
      @(negedge clk);
      reqAddr[0] = AW'(13); reqWdata[0] = pat(13, 9);
      #1 check("R3", $sformatf("ready %0d cycles after grant", k),
               80'(reqReady[0]), 80'(k >= BUSY));
    end
    model[13] = pat(13, 9);
    @(negedge clk); reqValid = '0; reqWrite = '0;
    readCheck(1, 5, model[5], 1'b1, 1'b0, 1'b0, "R3");
    readCheck(2, 13, model[13], 1'b1, 1'b0, 1'b0, "R3");

    // R4 priority among free banks
    repeat (BUSY) @(negedge clk);
    @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      reqValid[p] = 1'b1; reqWrite[p] = 1'b0; reqAddr[p] = AW'(p + 1);
    end
    #1 check("R4", "all three", 80'(reqReady), 80'(3'b001));
    @(negedge clk); reqValid[0] = 1'b0;
    #1 check("R4", "ports 1,2", 80'(reqReady), 80'(3'b010));
    @(negedge clk); reqValid[1] = 1'b0;
    #1 check("R4", "port 2", 80'(reqReady), 80'(3'b100));
    @(negedge clk); reqValid = '0;

    // R4 / R3 all ports on one bank
    repeat (BUSY) @(negedge clk);
    @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      reqValid[p] = 1'b1; reqAddr[p] = AW'(6 + 8 * p);
    end
    #1 check("R4", "same bank", 80'(reqReady), 80'(3'b001));
    for (int k = 1; k <= BUSY; k++) begin
      @(negedge clk);
      if (k == 1) reqValid[0] = 1'b0;
      #1 check("R3", $sformatf("same bank wait %0d", k), 80'(reqReady),
               80'((k >= BUSY) ? 3'b010 : 3'b000));
    end
    @(negedge clk); reqValid = '0;

    // R5 busy bank skipped in favour of lower priority
    repeat (BUSY) @(negedge clk);
    @(negedge clk);
    reqValid[0] = 1'b1; reqAddr[0] = AW'(2);
    #1 check("R5", "port0 alone", 80'(reqReady), 80'(3'b001));
    @(negedge clk);
    reqAddr[0] = AW'(10); reqValid[1] = 1'b1; reqAddr[1] = AW'(4);
    #1 check("R5", "skip busy", 80'(reqReady), 80'(3'b010));
    @(negedge clk); reqValid = '0;
    repeat (BUSY + 2) @(negedge clk);

    // R7 / R8 single flips in every codeword position
    for (int k = 0; k < 72; k++) begin
      int a;
      a = k % NW;
      model[a] = pat(a, k + 100);
      access(k % 3, a, 1'b1, model[a], 72'(1) << k, w);
      expCorr++;
      readCheck((k + 1) % 3, a, model[a], 1'b1, 1'b1, 1'b0, "R8");
    end

    // R7 / R9 double flips
    for (int k = 0; k < 72; k++) begin
      int a, j;
      a = (k * 5) % NW;
      j = (k + 1 + k % 7) % 72;
      access((k + 2) % 3, a, 1'b1, pat(a, k), (72'(1) << k) | (72'(1) << j), w);
      readCheck(k % 3, a, '0, 1'b0, 1'b1, 1'b1, "R9");
    end

    // R1 storage survives reset
    model[9] = pat(9, 55);
    access(0, 9, 1'b1, model[9], '0, w);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; expCorr = 0;
    @(negedge clk);
    check("R1", "corrCount after reset", 80'(corrCount), 80'(0));
    readCheck(2, 9, model[9], 1'b1, 1'b0, 1'b0, "R1");

    // corrected return in the same cycle as another grant
    model[20] = pat(20, 3); model[21] = pat(21, 3); model[22] = pat(22, 3);
    access(0, 20, 1'b1, model[20], 72'(1) << 37, w);
    access(1, 21, 1'b1, model[21], '0, w);
    access(2, 22, 1'b1, model[22], '0, w);
    expCorr++;
    repeat (BUSY) @(negedge clk);
    @(negedge clk);
    reqValid[1] = 1'b1; reqWrite[1] = 1'b0; reqAddr[1] = AW'(20);
    @(negedge clk);
    reqValid[1] = 1'b0; reqValid[2] = 1'b1; reqWrite[2] = 1'b0; reqAddr[2] = AW'(21);
    @(negedge clk);
    reqValid[2] = 1'b0; reqValid[0] = 1'b1; reqWrite[0] = 1'b0; reqAddr[0] = AW'(22);
    #1;
    check("R4", "grant during report", 80'(reqReady), 80'(3'b001));
    check("R6", "overlap rdValid", 80'(rdValid), 80'(3'b010));
    check("R8", "overlap rdData", 80'(rdData), 80'(model[20]));
    check("R8", "overlap errValid", 80'(errValid), 80'(1));
    check("R10", "overlap errPort", 80'(errPort), 80'(1));
    check("R10", "overlap errAddr", 80'(errAddr), 80'(20));
    check("R11", "overlap corrCount", 80'(corrCount), 80'(expCorr));
    @(negedge clk); reqValid = '0;
    check("R6", "second return", 80'(rdValid), 80'(3'b100));
    check("R6", "second data", 80'(rdData), 80'(model[21]));
    check("R12", "second clean", 80'(errValid), 80'(0));
    @(negedge clk);
    check("R6", "third return", 80'(rdValid), 80'(3'b001));
    check("R6", "third data", 80'(rdData), 80'(model[22]));
    check("R11", "count held", 80'(corrCount), 80'(expCorr));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog R1..R12 run incomplete actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule